// File: doc/BRIEF.md
# Paired General Register File

This block is the register storage of a small 8-bit processor core. It keeps six byte-wide general registers and two 16-bit pointers: a program counter and a stack pointer. Any single byte register can be read through either of two independent byte read ports, and written through a shared write port. The same six bytes can also be read and written as three fixed 16-bit pairs.

The program counter can be loaded with a full address, or advanced by one each time the core fetches an opcode byte. The stack pointer starts from a loaded 16-bit address. It moves down by one on a push and up by one on a pop. A push and a pop requested in the same cycle is reported as an error, and the stack pointer does not move.

Reads are combinational from the stored state, and writes take effect at the rising clock edge. A read in the same cycle as a write to the same register therefore returns the value held before the write. The general registers have no reset value.

Top module: `pair_regfile`

## Requirements
- R1: `rd_a_data` and `rd_b_data` each return the byte register named by their own select, with codes 0..5 meaning B, C, D, E, H, L; codes 6 and 7 read as zero.
- R2: With `wr_en`=1 and `wr_wide`=0, `wr_data[7:0]` is stored at the rising edge into the byte register coded by `wr_sel` (codes as in R1); codes 6 and 7 change no register.
- R3: `rd_pair_data` returns pair 0=BC, 1=DE or 2=HL as selected by `rd_pair_sel`, with B, D or H in bits 15:8 and C, E or L in bits 7:0; code 3 reads as zero.
- R4: With `wr_en`=1 and `wr_wide`=1, both bytes of the pair coded by `wr_pair_sel` are written at the same edge: `wr_data[15:8]` into the high register and `wr_data[7:0]` into the low one; code 3 changes no register.
- R5: A byte read or a pair read of a register that is written in the same cycle returns the value held before that edge.
- R6: While `rst_n` is low, the program counter and the stack pointer are cleared to 0x0000 and `sp_err` is 0.
- R7: `pc_load` loads `pc_load_val` at the edge and takes priority over `pc_inc`.
- R8: `pc_inc` without `pc_load` adds one to the program counter, wrapping from 0xFFFF to 0x0000; with neither strobe the program counter holds.
- R9: `sp_load` loads `sp_load_val` at the edge and takes priority over `sp_push` and `sp_pop`; with no strobe the stack pointer holds.
- R10: `sp_push` alone subtracts one from the stack pointer and `sp_pop` alone adds one, both wrapping modulo 2^16.
- R11: `sp_push` and `sp_pop` together without `sp_load` leave the stack pointer unchanged and raise `sp_err` for the following cycle only; in every other case `sp_err` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the pointers and the error flag |
| rd_a_sel | input | 3 | Byte register code for read port A |
| rd_b_sel | input | 3 | Byte register code for read port B |
| rd_a_data | output | 8 | Read port A data |
| rd_b_data | output | 8 | Read port B data |
| rd_pair_sel | input | 2 | Pair code for the 16-bit read port |
| rd_pair_data | output | 16 | Pair read data, high register in the upper byte |
| wr_en | input | 1 | Write strobe |
| wr_wide | input | 1 | 0: byte write, 1: pair write |
| wr_sel | input | 3 | Byte register code for a byte write |
| wr_pair_sel | input | 2 | Pair code for a pair write |
| wr_data | input | 16 | Write data; a byte write uses bits 7:0 |
| pc_load | input | 1 | Load the program counter |
| pc_inc | input | 1 | Advance the program counter by one |
| pc_load_val | input | 16 | Program counter load value |
| pc_out | output | 16 | Current program counter |
| sp_load | input | 1 | Load the stack pointer |
| sp_push | input | 1 | Push request, decrements the stack pointer |
| sp_pop | input | 1 | Pop request, increments the stack pointer |
| sp_load_val | input | 16 | Stack pointer load value |
| sp_out | output | 16 | Current stack pointer |
| sp_err | output | 1 | Push and pop were requested together in the previous cycle |

## Verification
The assertions check on every cycle how each pointer moves for every combination of its strobes, including the push-pop conflict and the one-cycle life of the error flag. They also check that every byte and pair write lands in the right storage slice and that an out-of-range write code leaves all storage still. The mapping from read codes to data and the byte order inside a pair can only be shown by the bench's sweeps, which compare every read code against values the bench tracks itself. The same holds for the old-value result of a read that meets a write in the same cycle.

// File: rtl/prf_pkg.sv
`timescale 1ns/1ps
package prf_pkg;

  typedef enum logic [1:0] {
    PC_HOLD = 2'd0,
    PC_LOAD = 2'd1,
    PC_STEP = 2'd2
  } pc_op_e;

  typedef enum logic [2:0] {
    SP_HOLD     = 3'd0,
    SP_LOAD     = 3'd1,
    SP_DOWN     = 3'd2,
    SP_UP       = 3'd3,
    SP_CONFLICT = 3'd4
  } sp_op_e;

  // Program counter: a load wins over a step.
  function automatic pc_op_e pc_decode(input logic load, input logic step);
    if (load)      return PC_LOAD;
    else if (step) return PC_STEP;
    else           return PC_HOLD;
  endfunction

  // Stack pointer: a load wins; push and pop together is a conflict.
  function automatic sp_op_e sp_decode(input logic load, input logic push,
                                       input logic pop);
    if (load)              return SP_LOAD;
    else if (push && pop)  return SP_CONFLICT;
    else if (push)         return SP_DOWN;
    else if (pop)          return SP_UP;
    else                   return SP_HOLD;
  endfunction

endpackage

// File: rtl/prf_byte_bank.sv
`timescale 1ns/1ps
module prf_byte_bank #(
  parameter int BYTE_W     = 8,
  parameter int NUM_PAIRS  = 3,
  parameter int SEL_W      = 3,
  parameter int PAIR_SEL_W = 2,
  localparam int NUM_REGS  = 2 * NUM_PAIRS,
  localparam int WIDE_W    = 2 * BYTE_W
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic                         wr_wide,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic [PAIR_SEL_W-1:0]        wr_pair_sel,
  input  logic [WIDE_W-1:0]            wr_data,
  input  logic [SEL_W-1:0]             rd_a_sel,
  input  logic [SEL_W-1:0]             rd_b_sel,
  input  logic [PAIR_SEL_W-1:0]        rd_pair_sel,
  output logic [BYTE_W-1:0]            rd_a_data,
  output logic [BYTE_W-1:0]            rd_b_data,
  output logic [WIDE_W-1:0]            rd_pair_data,
  output logic [NUM_REGS*BYTE_W-1:0]   bank_flat
);

  logic [BYTE_W-1:0] regs_q [NUM_REGS];

  // Even index = high byte of its pair, odd index = low byte.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic byte_hit;
    logic pair_hit;
    assign byte_hit = wr_en && !wr_wide && (wr_sel == SEL_W'(i));
    assign pair_hit = wr_en &&  wr_wide && (wr_pair_sel == PAIR_SEL_W'(i / 2));

    if ((i % 2) == 0) begin : g_high
      always_ff @(posedge clk) begin
        if (byte_hit)      regs_q[i] <= wr_data[BYTE_W-1:0];
        else if (pair_hit) regs_q[i] <= wr_data[WIDE_W-1:BYTE_W];
      end
    end else begin : g_low
      always_ff @(posedge clk) begin
        if (byte_hit)      regs_q[i] <= wr_data[BYTE_W-1:0];
        else if (pair_hit) regs_q[i] <= wr_data[BYTE_W-1:0];
      end
    end

    assign bank_flat[i*BYTE_W +: BYTE_W] = regs_q[i];
  end

  // Reads come straight from the stored state: a same-cycle write is not seen.
  always_comb begin
    rd_a_data = '0;
    rd_b_data = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_a_sel == SEL_W'(k)) rd_a_data = regs_q[k];
      if (rd_b_sel == SEL_W'(k)) rd_b_data = regs_q[k];
    end
  end

  always_comb begin
    rd_pair_data = '0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (rd_pair_sel == PAIR_SEL_W'(p))
        rd_pair_data = {regs_q[2*p], regs_q[2*p+1]};
    end
  end

endmodule

// File: rtl/prf_pc_unit.sv
`timescale 1ns/1ps
module prf_pc_unit #(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  prf_pkg::pc_op_e  op,
  input  logic [PTR_W-1:0] load_val,
  output logic [PTR_W-1:0] pc_q
);
  import prf_pkg::*;

  logic [PTR_W-1:0] pc_next;

  always_comb begin
    unique case (op)
      PC_LOAD: pc_next = load_val;
      PC_STEP: pc_next = pc_q + PTR_W'(1);
      default: pc_next = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_next;
  end

endmodule

// File: rtl/prf_sp_unit.sv
`timescale 1ns/1ps
module prf_sp_unit #(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  prf_pkg::sp_op_e  op,
  input  logic [PTR_W-1:0] load_val,
  output logic [PTR_W-1:0] sp_q,
  output logic             err_q
);
  import prf_pkg::*;

  logic [PTR_W-1:0] sp_next;

  always_comb begin
    unique case (op)
      SP_LOAD: sp_next = load_val;
      SP_DOWN: sp_next = sp_q - PTR_W'(1);
      SP_UP:   sp_next = sp_q + PTR_W'(1);
      default: sp_next = sp_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q  <= '0;
      err_q <= 1'b0;
    end else begin
      sp_q  <= sp_next;
      err_q <= (op == SP_CONFLICT);
    end
  end

endmodule

// File: rtl/pair_regfile.sv
`timescale 1ns/1ps
module pair_regfile #(
  parameter int BYTE_W     = 8,
  parameter int PTR_W      = 16,
  parameter int NUM_PAIRS  = 3,
  localparam int NUM_REGS   = 2 * NUM_PAIRS,
  localparam int SEL_W      = $clog2(NUM_REGS + 2),
  localparam int PAIR_SEL_W = $clog2(NUM_PAIRS + 1),
  localparam int WIDE_W     = 2 * BYTE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SEL_W-1:0]      rd_a_sel,
  input  logic [SEL_W-1:0]      rd_b_sel,
  output logic [BYTE_W-1:0]     rd_a_data,
  output logic [BYTE_W-1:0]     rd_b_data,
  input  logic [PAIR_SEL_W-1:0] rd_pair_sel,
  output logic [WIDE_W-1:0]     rd_pair_data,
  input  logic                  wr_en,
  input  logic                  wr_wide,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [PAIR_SEL_W-1:0] wr_pair_sel,
  input  logic [WIDE_W-1:0]     wr_data,
  input  logic                  pc_load,
  input  logic                  pc_inc,
  input  logic [PTR_W-1:0]      pc_load_val,
  output logic [PTR_W-1:0]      pc_out,
  input  logic                  sp_load,
  input  logic                  sp_push,
  input  logic                  sp_pop,
  input  logic [PTR_W-1:0]      sp_load_val,
  output logic [PTR_W-1:0]      sp_out,
  output logic                  sp_err
);
  import prf_pkg::*;

  pc_op_e                     pc_op;
  sp_op_e                     sp_op;
  logic [NUM_REGS*BYTE_W-1:0] bank_flat;

  assign pc_op = pc_decode(pc_load, pc_inc);
  assign sp_op = sp_decode(sp_load, sp_push, sp_pop);

  prf_byte_bank #(
    .BYTE_W(BYTE_W), .NUM_PAIRS(NUM_PAIRS),
    .SEL_W(SEL_W), .PAIR_SEL_W(PAIR_SEL_W)
  ) bank_i (
    .clk(clk), .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel),
    .wr_pair_sel(wr_pair_sel), .wr_data(wr_data),
    .rd_a_sel(rd_a_sel), .rd_b_sel(rd_b_sel), .rd_pair_sel(rd_pair_sel),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
    .rd_pair_data(rd_pair_data), .bank_flat(bank_flat)
  );

  prf_pc_unit #(.PTR_W(PTR_W)) pc_i (
    .clk(clk), .rst_n(rst_n), .op(pc_op), .load_val(pc_load_val), .pc_q(pc_out)
  );

  prf_sp_unit #(.PTR_W(PTR_W)) sp_i (
    .clk(clk), .rst_n(rst_n), .op(sp_op), .load_val(sp_load_val),
    .sp_q(sp_out), .err_q(sp_err)
  );

endmodule

// File: rtl/prf_checker.sv
`timescale 1ns/1ps
module prf_checker #(
  parameter int BYTE_W     = 8,
  parameter int PTR_W      = 16,
  parameter int NUM_PAIRS  = 3,
  parameter int SEL_W      = 3,
  parameter int PAIR_SEL_W = 2,
  localparam int NUM_REGS  = 2 * NUM_PAIRS,
  localparam int WIDE_W    = 2 * BYTE_W
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic                       wr_wide,
  input logic [SEL_W-1:0]           wr_sel,
  input logic [PAIR_SEL_W-1:0]      wr_pair_sel,
  input logic [WIDE_W-1:0]          wr_data,
  input logic                       pc_load,
  input logic                       pc_inc,
  input logic [PTR_W-1:0]           pc_load_val,
  input logic [PTR_W-1:0]           pc_out,
  input logic                       sp_load,
  input logic                       sp_push,
  input logic                       sp_pop,
  input logic [PTR_W-1:0]           sp_load_val,
  input logic [PTR_W-1:0]           sp_out,
  input logic                       sp_err,
  input logic [NUM_REGS*BYTE_W-1:0] bank_flat
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_byte_chk
    p_byte_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_wide && wr_sel == SEL_W'(i))
      |=> bank_flat[i*BYTE_W +: BYTE_W] == $past(wr_data[BYTE_W-1:0]));
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair_chk
    p_pair_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_wide && wr_pair_sel == PAIR_SEL_W'(p))
      |=> {bank_flat[2*p*BYTE_W +: BYTE_W], bank_flat[(2*p+1)*BYTE_W +: BYTE_W]}
          == $past(wr_data));
  end

  p_bad_code_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ((!wr_wide && wr_sel >= SEL_W'(NUM_REGS)) ||
               (wr_wide && wr_pair_sel >= PAIR_SEL_W'(NUM_PAIRS))))
    |=> $stable(bank_flat));

  p_pc_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> pc_out == $past(pc_load_val));

  p_pc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_inc && !pc_load) |=> pc_out == $past(pc_out) + PTR_W'(1));

  p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_inc && !pc_load) |=> $stable(pc_out));

  p_sp_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load |=> sp_out == $past(sp_load_val));

  p_sp_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_push && !sp_pop && !sp_load) |=> sp_out == $past(sp_out) - PTR_W'(1));

  p_sp_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_pop && !sp_push && !sp_load) |=> sp_out == $past(sp_out) + PTR_W'(1));

  p_sp_conflict_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_push && sp_pop && !sp_load) |=> ($stable(sp_out) && sp_err));

  p_sp_err_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(sp_push && sp_pop && !sp_load) |=> !sp_err);

endmodule

bind pair_regfile prf_checker #(
  .BYTE_W(BYTE_W), .PTR_W(PTR_W), .NUM_PAIRS(NUM_PAIRS),
  .SEL_W(SEL_W), .PAIR_SEL_W(PAIR_SEL_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel),
  .wr_pair_sel(wr_pair_sel), .wr_data(wr_data),
  .pc_load(pc_load), .pc_inc(pc_inc), .pc_load_val(pc_load_val), .pc_out(pc_out),
  .sp_load(sp_load), .sp_push(sp_push), .sp_pop(sp_pop),
  .sp_load_val(sp_load_val), .sp_out(sp_out), .sp_err(sp_err),
  .bank_flat(bank_flat)
);

// File: tb/pair_regfile_tb_top.sv
`timescale 1ns/1ps
module pair_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  rd_a_sel, rd_b_sel, wr_sel;
  logic [1:0]  rd_pair_sel, wr_pair_sel;
  logic [7:0]  rd_a_data, rd_b_data;
  logic [15:0] rd_pair_data, wr_data;
  logic        wr_en, wr_wide;
  logic        pc_load, pc_inc, sp_load, sp_push, sp_pop;
  logic [15:0] pc_load_val, pc_out, sp_load_val, sp_out;
  logic        sp_err;

  int n_checks = 0;
  int n_fails  = 0;
  logic [7:0]  exp_reg [6];
  logic [15:0] exp_pc, exp_sp;

  always #5 clk = ~clk;

  pair_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_sel(rd_a_sel), .rd_b_sel(rd_b_sel),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
    .rd_pair_sel(rd_pair_sel), .rd_pair_data(rd_pair_data),
    .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel),
    .wr_pair_sel(wr_pair_sel), .wr_data(wr_data),
    .pc_load(pc_load), .pc_inc(pc_inc), .pc_load_val(pc_load_val), .pc_out(pc_out),
    .sp_load(sp_load), .sp_push(sp_push), .sp_pop(sp_pop),
    .sp_load_val(sp_load_val), .sp_out(sp_out), .sp_err(sp_err)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int code);
    return (code < 6) ? exp_reg[code] : 8'h00;
  endfunction

  function automatic logic [15:0] exp_pair(input int code);
    return (code < 3) ? {exp_reg[2*code], exp_reg[2*code+1]} : 16'h0000;
  endfunction

  task automatic sweep_reads(input string req);
    for (int a = 0; a < 8; a++) begin
      rd_a_sel = 3'(a);
      rd_b_sel = 3'(7 - a);
      #1;
      check({req, " port A"}, {8'h00, rd_a_data}, {8'h00, exp_byte(a)});
      check({req, " port B"}, {8'h00, rd_b_data}, {8'h00, exp_byte(7 - a)});
    end
    for (int p = 0; p < 4; p++) begin
      rd_pair_sel = 2'(p);
      #1;
      check({req, " pair"}, rd_pair_data, exp_pair(p));
    end
  endtask

  task automatic idle_ptrs();
    pc_load = 0; pc_inc = 0; sp_load = 0; sp_push = 0; sp_pop = 0;
  endtask

  initial begin
    #(200000 * 10);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 0; rd_a_sel = 0; rd_b_sel = 0; rd_pair_sel = 0;
    wr_en = 0; wr_wide = 0; wr_sel = 0; wr_pair_sel = 0; wr_data = 0;
    pc_load_val = 16'h1234; sp_load_val = 16'h4321;
    idle_ptrs();
    pc_inc = 1; sp_push = 1; sp_pop = 1;
    repeat (3) tick();
    // R6: pointers and flag cleared under reset despite strobes
    check("R6 pc", pc_out, 16'h0000);
    check("R6 sp", sp_out, 16'h0000);
    check("R6 err", {15'b0, sp_err}, 16'h0000);
    idle_ptrs();
    rst_n = 1;
    tick();
    exp_pc = 0; exp_sp = 0;

    // R2 and R1: byte writes, two rounds, full read sweep after each
    for (int round = 0; round < 2; round++) begin
      for (int r = 0; r < 6; r++) begin
        wr_en = 1; wr_wide = 0; wr_sel = 3'(r);
        wr_data = {8'hEE, 8'((r * 37 + round * 91 + 5) & 8'hFF)};
        exp_reg[r] = wr_data[7:0];
        tick();
      end
      wr_en = 0;
      sweep_reads("R1 R2 R3");
    end

    // R2: invalid byte codes 6 and 7 change nothing
    for (int c = 6; c < 8; c++) begin
      wr_en = 1; wr_wide = 0; wr_sel = 3'(c); wr_data = 16'h5A5A;
      tick();
    end
    wr_en = 0;
    sweep_reads("R2 bad code");

    // R4: pair writes, high byte into B/D/H
    for (int p = 0; p < 3; p++) begin
      wr_en = 1; wr_wide = 1; wr_pair_sel = 2'(p);
      wr_data = 16'(16'hA100 + p * 16'h1111 + 16'h0F);
      exp_reg[2*p]   = wr_data[15:8];
      exp_reg[2*p+1] = wr_data[7:0];
      tick();
    end
    wr_en = 0;
    sweep_reads("R4 pair write");

    // R4: pair code 3 changes nothing
    wr_en = 1; wr_wide = 1; wr_pair_sel = 2'd3; wr_data = 16'hDEAD;
    tick();
    wr_en = 0;
    sweep_reads("R4 bad pair");

    // R5: read during same-cycle write sees old value
    rd_a_sel = 3'd0; rd_pair_sel = 2'd2;
    wr_en = 1; wr_wide = 0; wr_sel = 3'd0; wr_data = 16'h0077;
    #1;
    check("R5 byte old", {8'h00, rd_a_data}, {8'h00, exp_reg[0]});
    tick();
    exp_reg[0] = 8'h77;
    wr_en = 0;
    check("R5 byte new", {8'h00, rd_a_data}, {8'h00, exp_reg[0]});
    wr_en = 1; wr_wide = 1; wr_pair_sel = 2'd2; wr_data = 16'hBEEF;
    #1;
    check("R5 pair old", rd_pair_data, exp_pair(2));
    tick();
    exp_reg[4] = 8'hBE; exp_reg[5] = 8'hEF;
    wr_en = 0;
    check("R5 pair new", rd_pair_data, exp_pair(2));

    // R7 and R8: program counter
    pc_load = 1; pc_load_val = 16'hFFFD;
    tick(); exp_pc = 16'hFFFD;
    check("R7 load", pc_out, exp_pc);
    pc_load = 0; pc_inc = 1;
    for (int k = 0; k < 5; k++) begin
      tick(); exp_pc = exp_pc + 16'd1;
      check("R8 inc wrap", pc_out, exp_pc);
    end
    pc_inc = 0;
    repeat (2) tick();
    check("R8 hold", pc_out, exp_pc);
    pc_load = 1; pc_inc = 1; pc_load_val = 16'h0100;
    tick(); exp_pc = 16'h0100;
    check("R7 priority", pc_out, exp_pc);
    idle_ptrs();

    // R9, R10, R11: stack pointer
    sp_load = 1; sp_load_val = 16'h0001;
    tick(); exp_sp = 16'h0001;
    check("R9 load", sp_out, exp_sp);
    sp_load = 0; sp_push = 1;
    for (int k = 0; k < 3; k++) begin
      tick(); exp_sp = exp_sp - 16'd1;
      check("R10 push wrap", sp_out, exp_sp);
      check("R11 no err push", {15'b0, sp_err}, 16'h0000);
    end
    sp_push = 0; sp_pop = 1;
    for (int k = 0; k < 4; k++) begin
      tick(); exp_sp = exp_sp + 16'd1;
      check("R10 pop wrap", sp_out, exp_sp);
    end
    sp_pop = 0;
    tick();
    check("R9 hold", sp_out, exp_sp);
    sp_push = 1; sp_pop = 1;
    tick();
    check("R11 conflict sp", sp_out, exp_sp);
    check("R11 conflict err", {15'b0, sp_err}, 16'h0001);
    sp_push = 0; sp_pop = 0;
    tick();
    check("R11 err clears", {15'b0, sp_err}, 16'h0000);
    sp_load = 1; sp_push = 1; sp_pop = 1; sp_load_val = 16'h8000;
    tick(); exp_sp = 16'h8000;
    check("R9 priority", sp_out, exp_sp);
    check("R11 load no err", {15'b0, sp_err}, 16'h0000);
    idle_ptrs();
    tick();
    check("R8 pc untouched", pc_out, exp_pc);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule